// File: doc/BRIEF.md
# 1-Wire ROM Command Responder

This block is the slave-side identity layer of a 1-Wire device. It starts after each bus reset and presence sequence. It takes in one 8-bit ROM function code, then runs that function against the device's 64-bit identity. It works one bit slot at a time with a separate time-slot engine. When the engine finishes a slot, it raises `slot_done` for one clock and reports the sampled line level on `slot_val`. Whenever `tx_en` is high, the engine uses `tx_bit` as the bit the device drives in the next read slot.

The identity is fixed at build time from two parameters: an 8-bit family value and a 48-bit serial value. The block computes the top byte itself as a CRC of those 56 bits. Depending on the ROM function, the block does one of three things:
- It sends the identity out.
- It compares the identity with bits the master writes.
- It runs the search elimination process, bit by bit.

When a function succeeds, `selected` goes high to open the memory-function layer. When a function fails, the block parks and stays silent until the next bus reset.

Top module: `owr_rom_responder`

## Requirements
- R1: The identity holds the family value in bits [7:0] (default 04h) and the serial value in bits [55:8]. Bits [63:56] hold the CRC of bits [55:0] over x^8+x^5+x^4+1: the register starts at zero and bits enter LSB first. Running all 64 identity bits through the same register leaves zero.
- R2: The ROM code arrives in the first 8 slots after reset, least significant bit first. Code 33h selects read, 55h match, CCh skip, F0h search and ECh search-interrupt.
- R3: After read (33h), the block holds `tx_en` high and presents identity bit k on `tx_bit` for the k-th following slot, k = 0..63. After the 64th slot, `selected` goes high.
- R4: After match (55h), the block compares the next 64 written slots with identity bits 0..63. If all of them match, `selected` goes high after the 64th. On any mismatch, the block parks: `tx_en` stays low and `selected` stays low until a bus reset.
- R5: Skip (CCh) raises `selected` right after the 8th command slot.
- R6: After search (F0h), each identity bit takes three slots: the bit is sent, then its complement is sent, then the master's choice is read. A choice that differs from the bit parks the block. After bit 63 is accepted, `selected` goes high.
- R7: Search-interrupt (ECh) acts as search when `irq_pending` is high at the 8th command slot. Otherwise the block parks.
- R8: Any other command code parks the block: no bit is sent and no later slot can raise `selected` before a bus reset.
- R9: `bus_reset` returns the block to command reception from any state, with `tx_en` and `selected` low. It takes precedence over a `slot_done` in the same cycle.
- R10: While `tx_en` is high and no slot completes, `tx_bit` holds its value. Once high, `selected` stays high until a bus reset.
- R11: The synchronous `rst` puts the block into command reception with `tx_en` and `selected` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle strobe: a 1-Wire reset/presence sequence has completed |
| slot_done | input | 1 | One-cycle strobe: a bit slot has completed |
| slot_val | input | 1 | Line level sampled in the completed slot |
| irq_pending | input | 1 | An unacknowledged interrupt is pending |
| tx_en | output | 1 | The device drives the next read slot |
| tx_bit | output | 1 | Bit to drive when `tx_en` is high (1 when idle) |
| selected | output | 1 | ROM phase succeeded; memory functions may follow |

## Verification
A bus reset and a completed slot can arrive in the same clock. This happens when the slot engine finishes a slot just as the line is held low long enough to count as a reset. The bench provokes this by raising both strobes in one cycle partway through a read sequence. It then judges the outcome at the ports: `tx_en` must drop, `selected` must stay low, and a following skip command must select the device. That result shows the reset won and the slot was not counted. The bench also sweeps the failing bit position across all 64 positions for match and for search, and it sweeps every code that is not a command.

// File: rtl/owr_pkg.sv
package owr_pkg;

    localparam int CMD_W  = 8;
    localparam int BODY_W = 56;
    localparam int CRC_W  = 8;
    localparam int ID_W   = BODY_W + CRC_W;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SRCHIRQ = 8'hEC;

    // Reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    typedef logic [ID_W-1:0] ident_t;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_SEL,
        ST_PARK
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_CHOICE
    } srch_phase_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY_REFL;
        return n;
    endfunction

    function automatic logic [CRC_W-1:0] crc_of_body(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 0; i < BODY_W; i++) c = crc_step(c, body[i]);
        return c;
    endfunction

endpackage

// File: rtl/owr_id_rom.sv
module owr_id_rom
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h04,
    parameter logic [47:0] SERIAL = 48'h0
) (
    output ident_t id
);
    localparam logic [BODY_W-1:0] BODY = {SERIAL, FAMILY};
    localparam logic [CRC_W-1:0]  CRC  = crc_of_body(BODY);

    assign id = {CRC, BODY};
endmodule

// File: rtl/owr_cmd_rx.sv
module owr_cmd_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word_next,
    output logic         last
);
    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] cnt;

    // LSB-first: each new bit enters at the top and moves down
    assign word_next = {din, sreg[W-1:1]};
    assign last      = (cnt == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (shift) begin
            sreg <= word_next;
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/owr_bit_idx.sv
module owr_bit_idx #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 inc,
    output logic [$clog2(N)-1:0] idx,
    output logic                 at_last
);
    localparam int IW = $clog2(N);

    assign at_last = (idx == IW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)          idx <= '0;
        else if (inc && !at_last) idx <= idx + 1'b1;
    end
endmodule

// File: rtl/owr_rom_responder.sv
module owr_rom_responder
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h04,
    parameter logic [47:0] SERIAL = 48'h5C3A_9E17_B460
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic slot_done,
    input  logic slot_val,
    input  logic irq_pending,
    output logic tx_en,
    output logic tx_bit,
    output logic selected
);
    localparam int IW = $clog2(ID_W);

    rom_state_e  state, state_n;
    srch_phase_e phase, phase_n;

    ident_t          id;
    logic [CMD_W-1:0] cmd_word;
    logic            cmd_last;
    logic [IW-1:0]   idx;
    logic            idx_last;
    logic            idx_inc;
    logic            my_bit;
    logic            cmd_shift;

    owr_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
        .id (id)
    );

    assign cmd_shift = (state == ST_CMD) && slot_done && !bus_reset;

    owr_cmd_rx #(.W(CMD_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .clr       (bus_reset),
        .shift     (cmd_shift),
        .din       (slot_val),
        .word_next (cmd_word),
        .last      (cmd_last)
    );

    owr_bit_idx #(.N(ID_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .clr     (bus_reset),
        .inc     (idx_inc),
        .idx     (idx),
        .at_last (idx_last)
    );

    assign my_bit = id[idx];

    always_comb begin
        state_n = state;
        phase_n = phase;
        idx_inc = 1'b0;
        if (slot_done) begin
            unique case (state)
                ST_CMD: begin
                    if (cmd_last) begin
                        unique case (cmd_word)
                            OP_READ:    state_n = ST_READ;
                            OP_MATCH:   state_n = ST_MATCH;
                            OP_SKIP:    state_n = ST_SEL;
                            OP_SEARCH:  state_n = ST_SRCH;
                            OP_SRCHIRQ: state_n = irq_pending ? ST_SRCH : ST_PARK;
                            default:    state_n = ST_PARK;
                        endcase
                        phase_n = PH_TRUE;
                    end
                end
                ST_READ: begin
                    if (idx_last) state_n = ST_SEL;
                    else          idx_inc = 1'b1;
                end
                ST_MATCH: begin
                    if (slot_val != my_bit) state_n = ST_PARK;
                    else if (idx_last)      state_n = ST_SEL;
                    else                    idx_inc = 1'b1;
                end
                ST_SRCH: begin
                    unique case (phase)
                        PH_TRUE: phase_n = PH_COMP;
                        PH_COMP: phase_n = PH_CHOICE;
                        default: begin
                            phase_n = PH_TRUE;
                            if (slot_val != my_bit) state_n = ST_PARK;
                            else if (idx_last)      state_n = ST_SEL;
                            else                    idx_inc = 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
        if (bus_reset) begin
            state_n = ST_CMD;
            phase_n = PH_TRUE;
            idx_inc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CMD;
            phase <= PH_TRUE;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end

    always_comb begin
        tx_en  = (state == ST_READ) || ((state == ST_SRCH) && (phase != PH_CHOICE));
        tx_bit = 1'b1;
        if (tx_en) tx_bit = ((state == ST_SRCH) && (phase == PH_COMP)) ? ~my_bit : my_bit;
    end

    assign selected = (state == ST_SEL);
endmodule

// File: rtl/owr_rom_responder_chk.sv
module owr_rom_responder_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset,
    input logic slot_done,
    input logic tx_en,
    input logic tx_bit,
    input logic selected,
    input logic srch_first
);
    // R9: a bus reset always lands in command reception, silent and deselected
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!tx_en && !selected));

    // R10: selection persists until a bus reset
    assert_select_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (selected && !bus_reset) |=> selected);

    // R10: the offered bit does not change while waiting for a slot
    assert_txbit_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !slot_done && !bus_reset) |=> (tx_en && $stable(tx_bit)));

    // R2: selection only ever follows a completed slot
    assert_select_on_slot_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(selected) |-> $past(slot_done));

    // R6: the complement slot follows the true-bit slot with the opposite value
    assert_search_comp_R6: assert property (@(posedge clk) disable iff (rst)
        (srch_first && tx_en && slot_done && !bus_reset) |=> (tx_en && (tx_bit != $past(tx_bit))));

    // R3: the device never transmits while selected
    assert_no_tx_selected_R3: assert property (@(posedge clk) disable iff (rst)
        selected |-> !tx_en);
endmodule

bind owr_rom_responder owr_rom_responder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_reset  (bus_reset),
    .slot_done  (slot_done),
    .tx_en      (tx_en),
    .tx_bit     (tx_bit),
    .selected   (selected),
    .srch_first ((state == owr_pkg::ST_SRCH) && (phase == owr_pkg::PH_TRUE))
);

// File: tb/owr_rom_responder_tb_top.sv
module owr_rom_responder_tb_top;
    localparam logic [7:0]  TB_FAMILY = 8'h04;
    localparam logic [47:0] TB_SERIAL = 48'hA1B2_C3D4_E5F6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0;
    logic slot_done = 1'b0;
    logic slot_val = 1'b0;
    logic irq_pending = 1'b0;
    logic tx_en, tx_bit, selected;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [63:0] exp_id;
    logic [63:0] got_id;

    always #2 clk = ~clk;   // 250 MHz

    owr_rom_responder #(.FAMILY(TB_FAMILY), .SERIAL(TB_SERIAL)) dut_i (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .slot_done(slot_done),
        .slot_val(slot_val), .irq_pending(irq_pending),
        .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected)
    );

    function automatic logic [7:0] tb_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic fb = c[0] ^ v[i];
            c = {fb, c[7:5], c[4] ^ fb, c[3] ^ fb, c[2:1]};
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slot(input logic v);
        @(negedge clk);
        slot_done = 1'b1;
        slot_val  = v;
        @(negedge clk);
        slot_done = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) slot(c[i]);
    endtask

    // Read one device-driven bit, checking it against e
    task automatic rd(input logic e, input string req);
        chk(tx_en === 1'b1, req, tx_en, 1);
        chk(tx_bit === e, req, tx_bit, e);
        slot(tx_bit);
    endtask

    task automatic quiet(input string req);
        chk(tx_en === 1'b0, req, tx_en, 0);
        chk(selected === 1'b0, req, selected, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_id = {8'h00, TB_SERIAL, TB_FAMILY};
        exp_id[63:56] = tb_crc(exp_id, 56);

        repeat (3) @(negedge clk);
        quiet("R11 in reset");
        rst = 1'b0;
        @(negedge clk);
        quiet("R11 after reset");

        // R3 read ROM, R1 identity properties
        send_cmd(8'h33);
        for (int k = 0; k < 64; k++) begin
            got_id[k] = tx_bit;
            rd(exp_id[k], "R3 read bit");
        end
        chk(selected === 1'b1, "R3 select after read", selected, 1);
        chk(got_id[7:0] == 8'h04, "R1 family byte", got_id[7:0], 8'h04);
        chk(got_id[55:8] == TB_SERIAL, "R1 serial", got_id[55:8], TB_SERIAL);
        chk(tb_crc(got_id, 64) == 8'h00, "R1 crc residue", tb_crc(got_id, 64), 0);
        repeat (3) @(negedge clk);
        chk(selected === 1'b1, "R10 select holds", selected, 1);

        // R5 skip, R2 bit order (33h reversed is CCh)
        breset();
        for (int i = 0; i < 7; i++) slot(logic'((8'hCC >> i) & 1));
        chk(selected === 1'b0, "R5 not before 8th", selected, 0);
        slot(1'b1);
        chk(selected === 1'b1, "R5 skip select", selected, 1);
        breset();
        quiet("R9 reset from selected");

        // R4 match full
        send_cmd(8'h55);
        for (int k = 0; k < 64; k++) begin
            chk(tx_en === 1'b0, "R4 no tx in match", tx_en, 0);
            slot(exp_id[k]);
        end
        chk(selected === 1'b1, "R4 match select", selected, 1);

        // R4 mismatch sweep
        for (int m = 0; m < 64; m++) begin
            breset();
            send_cmd(8'h55);
            for (int k = 0; k < 64; k++) slot(k == m ? ~exp_id[k] : exp_id[k]);
            quiet("R4 mismatch parks");
        end

        // R6 search full
        breset();
        send_cmd(8'hF0);
        for (int k = 0; k < 64; k++) begin
            rd(exp_id[k], "R6 true bit");
            rd(~exp_id[k], "R6 comp bit");
            chk(tx_en === 1'b0, "R6 choice slot", tx_en, 0);
            slot(exp_id[k]);
        end
        chk(selected === 1'b1, "R6 search select", selected, 1);

        // R6 search elimination sweep
        for (int m = 0; m < 64; m++) begin
            breset();
            send_cmd(8'hF0);
            for (int k = 0; k < m; k++) begin
                slot(exp_id[k]); slot(~exp_id[k]); slot(exp_id[k]);
            end
            slot(exp_id[m]); slot(~exp_id[m]); slot(~exp_id[m]);
            quiet("R6 dropped out");
            slot(1'b0);
            quiet("R6 stays out");
        end

        // R7 search interrupt
        breset();
        irq_pending = 1'b0;
        send_cmd(8'hEC);
        quiet("R7 no irq parks");
        for (int k = 0; k < 12; k++) slot(1'b1);
        quiet("R7 no irq stays parked");
        breset();
        irq_pending = 1'b1;
        send_cmd(8'hEC);
        for (int k = 0; k < 64; k++) begin
            rd(exp_id[k], "R7 true bit");
            rd(~exp_id[k], "R7 comp bit");
            slot(exp_id[k]);
        end
        chk(selected === 1'b1, "R7 irq search select", selected, 1);
        irq_pending = 1'b0;

        // R8 every non-command code
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cc = 8'(c);
            if (cc == 8'h33 || cc == 8'h55 || cc == 8'hCC || cc == 8'hF0 || cc == 8'hEC) continue;
            breset();
            send_cmd(cc);
            chk(tx_en === 1'b0, "R8 unknown no tx", tx_en, 0);
            send_cmd(8'hCC);
            chk(selected === 1'b0, "R8 unknown no select", selected, 0);
        end

        // R9 reset and slot in the same cycle, R10 hold while idle
        breset();
        send_cmd(8'h33);
        for (int k = 0; k < 10; k++) rd(exp_id[k], "R9 pre read");
        repeat (4) @(negedge clk);
        chk(tx_en === 1'b1 && tx_bit === exp_id[10], "R10 bit held idle", tx_bit, exp_id[10]);
        @(negedge clk);
        bus_reset = 1'b1;
        slot_done = 1'b1;
        slot_val  = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        slot_done = 1'b0;
        quiet("R9 reset wins");
        send_cmd(8'hCC);
        chk(selected === 1'b1, "R9 cmd after collide", selected, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule